// File: doc/BRIEF.md
# Hotplug Slot Command Engine

This block is the command side of a hot-plug controller that looks after between 1 and 31 slots. Each slot has a small status record: a slot state, a power indicator, an attention indicator, a retention-latch (MRL) open flag and a presence code. Each slot also has an event latch. Software programs a target slot number and then writes a one-byte command code. The write of the code starts a short state machine (idle, decode, execute, done). That machine checks the request, updates one slot or walks all the slots one per cycle, records any error in a command status byte, and finally raises a command-detected flag.

The register port is a plain byte-wide write/read port. A write is always taken in the cycle it is presented, so there is no handshake and no back-pressure. Reads are combinational from the same address lines. Per-slot `slot_present_i` inputs are sampled only during synchronous reset, and they decide whether a slot starts out occupied or empty. Register offsets: 0x00 command code, 0x01 target (5 bits), 0x02 command status, 0x06 detect byte, and per slot `s` a group of four bytes at 0x08+4*s.

Top module: `hp_cmd_engine`

## Requirements
- R1: After reset, an occupied slot reads state 2 (enabled), power indicator 1 (on), MRL closed and presence 0. An empty slot reads state 3 (disabled), power indicator 3 (off), MRL open and presence 3. The slot byte at 0x08+4*s holds state in [1:0], power indicator in [3:2] and attention indicator in [5:4]. The byte at +1 holds MRL open in bit 0 and presence in [3:2].
- R2: Codes 0x00..0x3F act on slot (target-1). Bits [3:2] request the power indicator and bits [5:4] the attention indicator, where 0 keeps the value and 1/2/3 write on/blink/off.
- R3: Bits [1:0] of a slot code request a state, with 0 meaning keep. A disabled slot may go to power-only (1) or enabled (2), and a power-only or enabled slot may go to disabled (3). Every other request leaves the state unchanged and is not an error.
- R4: A target of 0 or above the slot count sets invalid-command (status bit 2) and changes no slot.
- R5: A power-only request on an enabled slot sets invalid-command and leaves every field of that slot unchanged, indicators included.
- R6: A move to disabled whose resulting power indicator is off sets MRL open and presence 3, and sets bits 0 (presence) and 3 (MRL) of the slot's event latch at byte +2.
- R7: Codes 0x40..0x47 choose bus speed from bits [2:0]. Speed 0 is accepted without effect, and any other speed sets invalid-mode (status bit 3).
- R8: Code 0x48 (all power-only) and code 0x49 (all enabled) set invalid-command if any slot is enabled. Otherwise each slot with MRL closed is sent that state with power indicator on, and each slot with MRL open gets power indicator off, both under the R3 rules.
- R9: Any other code sets invalid-command. Starting a command clears status bits 1..3. Finishing any command sets the detect flag (byte 0x06 bit 0, bit 16 of the 32-bit word at 0x04), and writing 1 there clears it unless a finish falls in the same cycle.
- R10: Status bit 0 (busy) reads 1 for exactly 2 cycles after the code write for rejected, speed and unknown codes, 3 cycles for an accepted slot command, and slot count + 2 cycles for an accepted bulk command.
- R11: Code and target writes made while busy are ignored. A target write on its own starts nothing.
- R12: Writing 1s to an event latch byte clears those bits, but a bit that the engine sets in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_present_i | input | NUM_SLOTS | Occupancy of each slot, sampled during reset |
| reg_wr_i | input | 1 | Byte write strobe |
| reg_addr_i | input | ADDR_W | Byte address for write and read |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data at reg_addr_i |

## Verification
Two pairs of actions can land on the same clock edge. In the first pair, software clears the detect flag in the cycle the engine finishes a command. In the second, software write-one-clears an event latch in the cycle the engine marks that slot empty. The bench places each clearing write on the exact edge that the behavioural model predicts from the command latency. It then expects the set to win, so the flag and the latch bits remain 1. A code write placed during busy is judged by unchanged busy length and unchanged slot records.

// File: rtl/hp_cmd_pkg.sv
package hp_cmd_pkg;

  localparam logic [1:0] ST_KEEP = 2'd0;
  localparam logic [1:0] ST_PWR  = 2'd1;
  localparam logic [1:0] ST_EN   = 2'd2;
  localparam logic [1:0] ST_DIS  = 2'd3;

  localparam logic [1:0] LED_KEEP = 2'd0;
  localparam logic [1:0] LED_ON   = 2'd1;
  localparam logic [1:0] LED_OFF  = 2'd3;

  localparam logic [1:0] PRS_LOW   = 2'd0;
  localparam logic [1:0] PRS_EMPTY = 2'd3;

  localparam int EV_W        = 5;
  localparam int EV_PRESENCE = 0;
  localparam int EV_MRL      = 3;

  localparam int OFS_CODE  = 0;
  localparam int OFS_TGT   = 1;
  localparam int OFS_STAT  = 2;
  localparam int OFS_DET   = 6;
  localparam int SLOT_BASE = 8;
  localparam int SLOT_STRIDE = 4;

  typedef struct packed {
    logic       mrl_open;
    logic [1:0] prs;
    logic [1:0] attn;
    logic [1:0] pwr;
    logic [1:0] state;
  } slot_rec_t;

  typedef enum logic [1:0] {FS_IDLE, FS_DECODE, FS_EXEC, FS_DONE} fsm_e;

  typedef enum logic [2:0] {K_SLOT, K_SPEED, K_ALL_PWR, K_ALL_EN, K_BAD} kind_e;

  function automatic kind_e cmd_kind(input logic [7:0] c);
    if (c[7:6] == 2'b00) return K_SLOT;
    if (c[7:3] == 5'b01000) return K_SPEED;
    if (c == 8'h48) return K_ALL_PWR;
    if (c == 8'h49) return K_ALL_EN;
    return K_BAD;
  endfunction

endpackage

// File: rtl/hp_slot_xform.sv
module hp_slot_xform
  import hp_cmd_pkg::*;
(
  input  slot_rec_t        cur_i,
  input  logic [1:0]       req_state_i,
  input  logic [1:0]       req_pwr_i,
  input  logic [1:0]       req_attn_i,
  output slot_rec_t        nxt_o,
  output logic [EV_W-1:0]  ev_set_o,
  output logic             reject_o
);

  always_comb begin
    reject_o = (cur_i.state == ST_EN) && (req_state_i == ST_PWR);
    nxt_o    = cur_i;
    ev_set_o = '0;
    if (req_pwr_i != LED_KEEP) nxt_o.pwr = req_pwr_i;
    if (req_attn_i != LED_KEEP) nxt_o.attn = req_attn_i;
    if (cur_i.state == ST_DIS && (req_state_i == ST_PWR || req_state_i == ST_EN)) begin
      nxt_o.state = req_state_i;
    end else if ((cur_i.state == ST_EN || cur_i.state == ST_PWR) && req_state_i == ST_DIS) begin
      nxt_o.state = ST_DIS;
      if (nxt_o.pwr == LED_OFF) begin
        nxt_o.mrl_open = 1'b1;
        nxt_o.prs      = PRS_EMPTY;
        ev_set_o[EV_PRESENCE] = 1'b1;
        ev_set_o[EV_MRL]      = 1'b1;
      end
    end
    if (reject_o) begin
      nxt_o    = cur_i;
      ev_set_o = '0;
    end
  end

endmodule

// File: rtl/hp_slot_cell.sv
module hp_slot_cell
  import hp_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            present_i,
  input  logic            apply_i,
  input  slot_rec_t       nxt_i,
  input  logic [EV_W-1:0] ev_set_i,
  input  logic [EV_W-1:0] clr_i,
  output slot_rec_t       rec_o,
  output logic [EV_W-1:0] latch_o
);

  slot_rec_t rst_rec;

  always_comb begin
    if (present_i) begin
      rst_rec = '{mrl_open: 1'b0, prs: PRS_LOW, attn: LED_KEEP, pwr: LED_ON, state: ST_EN};
    end else begin
      rst_rec = '{mrl_open: 1'b1, prs: PRS_EMPTY, attn: LED_KEEP, pwr: LED_OFF, state: ST_DIS};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_o   <= rst_rec;
      latch_o <= '0;
    end else begin
      if (apply_i) rec_o <= nxt_i;
      latch_o <= (latch_o & ~clr_i) | (apply_i ? ev_set_i : '0);
    end
  end

  // R12: an engine-set MRL event survives a same-cycle clear
  p_latch_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && ev_set_i[EV_MRL]) |=> latch_o[EV_MRL]);

endmodule

// File: rtl/hp_cmd_fsm.sv
module hp_cmd_fsm
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       code_i,
  input  logic [4:0]       target_i,
  input  logic             any_enabled_i,
  input  logic             sel_mrl_open_i,
  input  logic             reject_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic             sel_valid_o,
  output logic [1:0]       req_state_o,
  output logic [1:0]       req_pwr_o,
  output logic [1:0]       req_attn_o,
  output logic             apply_o,
  output logic             set_inv_cmd_o,
  output logic             set_inv_mode_o,
  output logic             set_det_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  fsm_e             state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  kind_e            kind;
  logic             in_range;
  logic             bulk;

  assign kind     = cmd_kind(code_i);
  assign bulk     = (kind == K_ALL_PWR) || (kind == K_ALL_EN);
  assign in_range = (target_i != 5'd0) && ({1'b0, target_i} <= 6'(NUM_SLOTS));
  assign busy_o   = (state_q != FS_IDLE);

  always_comb begin
    if (kind == K_SLOT) begin
      sel_idx_o   = IDX_W'(target_i - 5'd1);
      sel_valid_o = in_range;
      req_state_o = code_i[1:0];
      req_pwr_o   = code_i[3:2];
      req_attn_o  = code_i[5:4];
    end else begin
      sel_idx_o   = idx_q;
      sel_valid_o = bulk;
      req_attn_o  = LED_KEEP;
      if (!sel_mrl_open_i) begin
        req_state_o = (kind == K_ALL_PWR) ? ST_PWR : ST_EN;
        req_pwr_o   = LED_ON;
      end else begin
        req_state_o = ST_KEEP;
        req_pwr_o   = LED_OFF;
      end
    end
  end

  always_comb begin
    state_d        = state_q;
    idx_d          = idx_q;
    apply_o        = 1'b0;
    set_inv_cmd_o  = 1'b0;
    set_inv_mode_o = 1'b0;
    set_det_o      = 1'b0;
    unique case (state_q)
      FS_IDLE: if (start_i) state_d = FS_DECODE;
      FS_DECODE: begin
        case (kind)
          K_SLOT: begin
            if (!in_range || reject_i) begin
              set_inv_cmd_o = 1'b1;
              state_d = FS_DONE;
            end else begin
              state_d = FS_EXEC;
            end
          end
          K_SPEED: begin
            set_inv_mode_o = (code_i[2:0] != 3'd0);
            state_d = FS_DONE;
          end
          K_ALL_PWR, K_ALL_EN: begin
            if (any_enabled_i) begin
              set_inv_cmd_o = 1'b1;
              state_d = FS_DONE;
            end else begin
              idx_d   = '0;
              state_d = FS_EXEC;
            end
          end
          default: begin
            set_inv_cmd_o = 1'b1;
            state_d = FS_DONE;
          end
        endcase
      end
      FS_EXEC: begin
        apply_o = 1'b1;
        if (!bulk || idx_q == LAST_IDX) state_d = FS_DONE;
        else idx_d = idx_q + 1'b1;
      end
      FS_DONE: begin
        set_det_o = 1'b1;
        state_d   = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // R10: a start in idle makes the engine busy next cycle
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == FS_IDLE) |=> busy_o);

  // R10: the done step always returns to idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_DONE) |=> (state_q == FS_IDLE));

  // R4, R5: a rejected decode never reaches an execute step
  p_reject_noapply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_DECODE && set_inv_cmd_o) |=> !apply_o);

endmodule

// File: rtl/hp_cmd_engine.sv
module hp_cmd_engine
  import hp_cmd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W = $clog2(SLOT_BASE + SLOT_STRIDE * NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_present_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [7:0]       code_q;
  logic [4:0]       tgt_q;
  logic             inv_cmd_q, inv_mode_q, det_q;
  logic             busy, start, wr_code, wr_tgt, wr_det;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_valid;
  logic [1:0]       req_state, req_pwr, req_attn;
  logic             apply, set_inv_cmd, set_inv_mode, set_det;
  logic             any_enabled, reject;
  slot_rec_t        sel_rec, nxt_rec;
  logic [EV_W-1:0]  ev_set;
  slot_rec_t        recs    [NUM_SLOTS];
  logic [EV_W-1:0]  latches [NUM_SLOTS];

  assign wr_code = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CODE));
  assign wr_tgt  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_TGT));
  assign wr_det  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_DET)) && reg_wdata_i[0];
  assign start   = wr_code && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q     <= '0;
      tgt_q      <= '0;
      inv_cmd_q  <= 1'b0;
      inv_mode_q <= 1'b0;
      det_q      <= 1'b0;
    end else begin
      if (start) code_q <= reg_wdata_i;
      if (wr_tgt && !busy) tgt_q <= reg_wdata_i[4:0];
      if (start) begin
        inv_cmd_q  <= 1'b0;
        inv_mode_q <= 1'b0;
      end else begin
        if (set_inv_cmd)  inv_cmd_q  <= 1'b1;
        if (set_inv_mode) inv_mode_q <= 1'b1;
      end
      det_q <= (det_q && !wr_det) || set_det;
    end
  end

  always_comb begin
    sel_rec     = '0;
    any_enabled = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (sel_valid && sel_idx == IDX_W'(s)) sel_rec = recs[s];
      if (recs[s].state == ST_EN) any_enabled = 1'b1;
    end
  end

  hp_cmd_fsm #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .code_i         (code_q),
    .target_i       (tgt_q),
    .any_enabled_i  (any_enabled),
    .sel_mrl_open_i (sel_rec.mrl_open),
    .reject_i       (reject),
    .busy_o         (busy),
    .sel_idx_o      (sel_idx),
    .sel_valid_o    (sel_valid),
    .req_state_o    (req_state),
    .req_pwr_o      (req_pwr),
    .req_attn_o     (req_attn),
    .apply_o        (apply),
    .set_inv_cmd_o  (set_inv_cmd),
    .set_inv_mode_o (set_inv_mode),
    .set_det_o      (set_det)
  );

  hp_slot_xform u_xform (
    .cur_i       (sel_rec),
    .req_state_i (req_state),
    .req_pwr_i   (req_pwr),
    .req_attn_i  (req_attn),
    .nxt_o       (nxt_rec),
    .ev_set_o    (ev_set),
    .reject_o    (reject)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic            hit_clr;
    logic            hit_apply;
    logic [EV_W-1:0] clr;
    assign hit_clr   = reg_wr_i && (reg_addr_i == ADDR_W'(SLOT_BASE + SLOT_STRIDE * s + 2));
    assign clr       = hit_clr ? reg_wdata_i[EV_W-1:0] : '0;
    assign hit_apply = apply && sel_valid && (sel_idx == IDX_W'(s));
    hp_slot_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .present_i (slot_present_i[s]),
      .apply_i   (hit_apply),
      .nxt_i     (nxt_rec),
      .ev_set_i  (ev_set),
      .clr_i     (clr),
      .rec_o     (recs[s]),
      .latch_o   (latches[s])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(OFS_CODE)) reg_rdata_o = code_q;
    if (reg_addr_i == ADDR_W'(OFS_TGT))  reg_rdata_o = {3'b000, tgt_q};
    if (reg_addr_i == ADDR_W'(OFS_STAT)) reg_rdata_o = {4'b0000, inv_mode_q, inv_cmd_q, 1'b0, busy};
    if (reg_addr_i == ADDR_W'(OFS_DET))  reg_rdata_o = {7'b0000000, det_q};
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (reg_addr_i == ADDR_W'(SLOT_BASE + SLOT_STRIDE * s))
        reg_rdata_o = {2'b00, recs[s].attn, recs[s].pwr, recs[s].state};
      if (reg_addr_i == ADDR_W'(SLOT_BASE + SLOT_STRIDE * s + 1))
        reg_rdata_o = {4'b0000, recs[s].prs, 1'b0, recs[s].mrl_open};
      if (reg_addr_i == ADDR_W'(SLOT_BASE + SLOT_STRIDE * s + 2))
        reg_rdata_o = 8'(latches[s]);
    end
  end

  // R5: the shared transform never applies a refused request
  p_no_reject_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply && reject));

  // R9: finishing a command always leaves the detect flag set
  p_detect_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_det |=> det_q);

  // R11: a code write during busy does not disturb the held code
  p_busy_code_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_code) |=> $stable(code_q));

endmodule

// File: tb/hp_cmd_engine_tb.sv
`timescale 1ns/1ps
module hp_cmd_engine_tb;

  localparam int NS = 4;
  localparam int AW = $clog2(8 + 4 * NS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] present = 4'b0101;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;

  int checks = 0;
  int errors = 0;

  int m_st [NS];
  int m_pw [NS];
  int m_at [NS];
  int m_mrl[NS];
  int m_prs[NS];
  int m_lat[NS];
  int m_invc = 0, m_invm = 0, m_det = 0, m_tgt = 0;

  always #2.5 clk = ~clk;

  hp_cmd_engine #(.NUM_SLOTS(NS)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_present_i (present),
    .reg_wr_i       (reg_wr),
    .reg_addr_i     (reg_addr),
    .reg_wdata_i    (reg_wdata),
    .reg_rdata_o    (reg_rdata)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic rd(int a, output int v);
    reg_addr = AW'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // behavioural model of one slot update; returns 1 when refused
  function automatic bit m_slot(int i, int rs, int rp, int ra);
    if (m_st[i] == 2 && rs == 1) return 1'b1;
    if (rp != 0) m_pw[i] = rp;
    if (ra != 0) m_at[i] = ra;
    if (m_st[i] == 3 && (rs == 1 || rs == 2)) m_st[i] = rs;
    else if ((m_st[i] == 1 || m_st[i] == 2) && rs == 3) begin
      m_st[i] = 3;
      if (m_pw[i] == 3) begin
        m_mrl[i] = 1; m_prs[i] = 3; m_lat[i] = m_lat[i] | 9;
      end
    end
    return 1'b0;
  endfunction

  // returns expected busy cycle count
  function automatic int m_cmd(int code, int tgt);
    bit any_en = 1'b0;
    m_invc = 0; m_invm = 0;
    if (code < 64) begin
      if (tgt < 1 || tgt > NS) begin m_invc = 1; return 2; end
      if (m_slot(tgt - 1, code & 3, (code >> 2) & 3, (code >> 4) & 3)) begin
        m_invc = 1; return 2;
      end
      return 3;
    end
    if (code < 72) begin
      if ((code & 7) != 0) m_invm = 1;
      return 2;
    end
    if (code == 72 || code == 73) begin
      foreach (m_st[i]) if (m_st[i] == 2) any_en = 1'b1;
      if (any_en) begin m_invc = 1; return 2; end
      foreach (m_st[i]) begin
        if (m_mrl[i] == 0) void'(m_slot(i, (code == 72) ? 1 : 2, 1, 0));
        else void'(m_slot(i, 0, 3, 0));
      end
      return NS + 2;
    end
    m_invc = 1;
    return 2;
  endfunction

  task automatic compare_all(string tag);
    int v;
    for (int s = 0; s < NS; s++) begin
      rd(8 + 4 * s, v);
      chk(tag, $sformatf("slot%0d ctl", s), v, (m_at[s] << 4) | (m_pw[s] << 2) | m_st[s]);
      rd(9 + 4 * s, v);
      chk(tag, $sformatf("slot%0d sense", s), v, (m_prs[s] << 2) | m_mrl[s]);
      rd(10 + 4 * s, v);
      chk(tag, $sformatf("slot%0d latch", s), v, m_lat[s]);
    end
    rd(2, v);
    chk(tag, "status", v, (m_invm << 3) | (m_invc << 2));
    rd(6, v);
    chk(tag, "detect", v, m_det);
  endtask

  // issue a command; optionally inject one write at sample k == inj_k
  task automatic run_cmd(int code, string tag, int inj_k = 0, int inj_a = 0, int inj_d = 0);
    int len, v;
    len = m_cmd(code, m_tgt);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(0); reg_wdata = 8'(code);
    @(negedge clk);
    reg_wr = 1'b0;
    for (int k = 1; k <= len + 1; k++) begin
      rd(2, v);
      chk("R10", $sformatf("busy k=%0d code=%0h", k, code), v & 1, (k <= len) ? 1 : 0);
      if (k == inj_k) begin
        reg_wr = 1'b1; reg_addr = AW'(inj_a); reg_wdata = 8'(inj_d);
      end
      if (k <= len) begin
        @(negedge clk);
        reg_wr = 1'b0;
      end
    end
    m_det = 1;
    compare_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      if (present[s]) begin m_st[s] = 2; m_pw[s] = 1; m_mrl[s] = 0; m_prs[s] = 0; end
      else begin m_st[s] = 3; m_pw[s] = 3; m_mrl[s] = 1; m_prs[s] = 3; end
      m_at[s] = 0; m_lat[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");

    // R11: target alone starts nothing
    wr(1, 1); m_tgt = 1;
    compare_all("R11");

    run_cmd(8'h49, "R8");                 // refused: slot 0 enabled
    run_cmd(8'h28, "R2");                 // both indicators blink
    run_cmd(8'h05, "R5");                 // power-only on enabled: refused
    wr(6, 1); m_det = 0;                  // R9 detect clear
    compare_all("R9");

    wr(1, 0); m_tgt = 0;
    run_cmd(8'h30, "R4");
    wr(1, 5); m_tgt = 5;
    run_cmd(8'h30, "R4");

    // R11: code write during busy is dropped
    wr(1, 4); m_tgt = 4;
    run_cmd(8'h10, "R11", 1, 0, 8'h3C);

    wr(1, 2); m_tgt = 2;
    run_cmd(8'h02, "R3");                 // disabled -> enabled
    run_cmd(8'h03, "R6");                 // enabled -> disabled, indicator off
    wr(14, 8'h08); m_lat[1] = m_lat[1] & ~8;
    compare_all("R12");

    wr(1, 1); m_tgt = 1;
    run_cmd(8'h03, "R3");                 // enabled -> disabled, blink keeps slot
    run_cmd(8'h01, "R3");                 // disabled -> power-only
    run_cmd(8'h02, "R3");                 // power-only -> enabled not allowed

    // R12: engine empties slot 2 in the cycle its latch is cleared
    wr(1, 3); m_tgt = 3;
    run_cmd(8'h0F, "R12", 2, 18, 8'hFF);

    run_cmd(8'h40, "R7");
    run_cmd(8'h43, "R7");
    // R9: detect clear coinciding with finish
    run_cmd(8'h50, "R9", 2, 6, 1);

    wr(1, 1); m_tgt = 1;
    run_cmd(8'h03, "R3");                 // power-only -> disabled
    run_cmd(8'h48, "R8");                 // bulk power-only accepted
    run_cmd(8'h49, "R8");                 // nothing enabled, power-only stays
    run_cmd(8'h03, "R3");
    run_cmd(8'h49, "R8");                 // slot 0 enabled by bulk
    run_cmd(8'h48, "R8");                 // refused: slot 0 enabled

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule